// File: doc/BRIEF.md
# Self-Timed Page Write Sequencer

This block sits between the serial front end of a small non-volatile memory and its storage array. While a write transaction is on the bus, the front end hands it the target address, the kind of command and each received data byte. The block stages the bytes in a page buffer whose column pointer wraps inside the page. When the host ends the transaction with a stop, the block enters a self-timed busy period of fixed length. At the end of that period it commits the whole page to the array in one wide write, or it applies the protection-register operation that was requested.

The busy output tells the front end to refuse every acknowledge. This lets a host poll for completion by sending a slave address until it gets an acknowledge back. New commands that arrive while busy is high have no effect.

The write-protect pin is watched only inside a cancel window. The window opens at the clock edge that captures bit 0 of the first data byte. It stays open through the staging phase and the whole busy period. If the pin is high inside the window before the stop, the staged page is thrown away. If it is high during the busy period, the cycle is cut short and the bytes that were being written are overwritten with 00h, so the damage can be seen. A supply-low input blocks the start of any cycle.

Top module: `wr_cycle_seq`

## Requirements
- R1: After reset, busy, mem_we, prot_we and aborted are low, and the page buffer holds no bytes.
- R2: A busy period starts only on a wr_start pulse that follows a first_d0 pulse in the same transaction. A wr_start with no data before it leaves busy low.
- R3: After a cycle starts, busy stays high for exactly WR_CYCLES clock cycles. The commit pulse (mem_we or prot_we) is high during the first cycle in which busy is low again.
- R4: For command kind 0 (page write), byte k of the transaction goes to column (start address mod PAGE_BYTES + k) mod PAGE_BYTES. A later byte overwrites an earlier byte in the same column. At commit, mem_be marks the columns that were received, mem_row equals the start address divided by PAGE_BYTES, and columns that were not received read 00h in mem_wdata.
- R5: While busy is high, txn_begin, first_d0, byte_valid and wr_start have no effect. The commit carries the page that was staged before the stop, and no second cycle follows.
- R6: For kinds 1 (set protection), 2 (clear protection) and 3 (permanent protection), the commit is a one-cycle prot_we pulse with prot_op equal to the kind, and mem_we stays low.
- R7: If wp_pin is high in a busy cycle, busy falls on the next cycle, even in the last busy cycle. For a page write, that same cycle carries mem_we with the staged mem_be, mem_wdata all zero, and an aborted pulse.
- R8: If wp_pin is high after first_d0 but before the stop, the staged page is dropped. The following bytes and the wr_start start no cycle.
- R9: If wp_pin is high before first_d0, it has no effect on the transaction.
- R10: If supply_low is high with wr_start, no cycle starts and the command is dropped. A second wr_start without a new transaction starts nothing either.
- R11: An abort during a protection command pulses aborted, gives no prot_we and gives no mem_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_begin | input | 1 | A new write transaction has been addressed; loads the address and kind |
| txn_addr | input | ADDR_W | Start word address of the transaction |
| txn_kind | input | 2 | Command kind: 0 page, 1 set protection, 2 clear protection, 3 permanent protection |
| first_d0 | input | 1 | Clock edge that captures bit 0 of the first data byte |
| byte_valid | input | 1 | A data byte has been received |
| byte_data | input | 8 | Received data byte |
| wr_start | input | 1 | Stop condition seen after the write command |
| wp_pin | input | 1 | Synchronised write-protect pin |
| supply_low | input | 1 | Supply below the safe write level |
| busy | output | 1 | Self-timed cycle in progress; the front end refuses acknowledges |
| mem_we | output | 1 | Array page write strobe |
| mem_row | output | ADDR_W-log2(PAGE_BYTES) | Page row address of the write |
| mem_be | output | PAGE_BYTES | Per-column byte enables |
| mem_wdata | output | 8*PAGE_BYTES | Page data, column 0 in the low byte |
| prot_we | output | 1 | Protection-register update strobe |
| prot_op | output | 2 | Protection operation, equal to the command kind |
| aborted | output | 1 | The cycle was cut short by the write-protect pin |

## Verification
The bench builds the block with WR_CYCLES set to 40 and keeps the default page of 16 bytes at 8 address bits. The short busy time allows whole write, abort and poll sequences, commands injected during a busy period, and aborts timed to an exact cycle, all within a short run. The full page gives an 18-byte transfer that starts near the end of a page and wraps twice over the same columns.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

    typedef enum logic [1:0] {
        KIND_PAGE      = 2'd0,
        KIND_PROT_SET  = 2'd1,
        KIND_PROT_CLR  = 2'd2,
        KIND_PROT_LOCK = 2'd3
    } wr_kind_e;

endpackage

// File: rtl/wcs_page_buf.sv
module wcs_page_buf #(
    parameter int ADDR_W     = 8,
    parameter int PAGE_BYTES = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            set_base,
    input  logic [ADDR_W-1:0]               base_addr,
    input  logic                            clr,
    input  logic                            push,
    input  logic [7:0]                      push_data,
    output logic [PAGE_BYTES-1:0]           mask,
    output logic [PAGE_BYTES*8-1:0]         data,
    output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] row
);
    localparam int PG_W  = $clog2(PAGE_BYTES);
    localparam int ROW_W = ADDR_W - PG_W;

    typedef struct packed {
        logic [PAGE_BYTES-1:0]      mask;
        logic [PAGE_BYTES-1:0][7:0] bytes;
        logic [ROW_W-1:0]           row;
        logic [PG_W-1:0]            ptr;
    } stage_t;

    stage_t q, d;

    // Clearing the bytes together with the mask makes unreceived columns read zero.
    always_comb begin
        d = q;
        if (set_base) begin
            d.row   = base_addr[ADDR_W-1:PG_W];
            d.ptr   = base_addr[PG_W-1:0];
            d.mask  = '0;
            d.bytes = '0;
        end else if (clr) begin
            d.mask  = '0;
            d.bytes = '0;
        end else if (push) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (q.ptr == PG_W'(i)) begin
                    d.bytes[i] = push_data;
                    d.mask[i]  = 1'b1;
                end
            end
            d.ptr = q.ptr + PG_W'(1);   // wraps inside the page
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mask = q.mask;
    assign data = q.bytes;
    assign row  = q.row;

endmodule

// File: rtl/wcs_busy_timer.sv
module wcs_busy_timer #(
    parameter int WR_CYCLES = 625000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                      cnt_d = CNT_W'(WR_CYCLES - 1);
        else if (run && cnt_q != '0)   cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/wr_cycle_seq.sv
module wr_cycle_seq #(
    parameter int ADDR_W     = 8,
    parameter int PAGE_BYTES = 16,
    parameter int WR_CYCLES  = 625000
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   txn_begin,
    input  logic [ADDR_W-1:0]                      txn_addr,
    input  logic [1:0]                             txn_kind,
    input  logic                                   first_d0,
    input  logic                                   byte_valid,
    input  logic [7:0]                             byte_data,
    input  logic                                   wr_start,
    input  logic                                   wp_pin,
    input  logic                                   supply_low,
    output logic                                   busy,
    output logic                                   mem_we,
    output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]   mem_row,
    output logic [PAGE_BYTES-1:0]                  mem_be,
    output logic [PAGE_BYTES*8-1:0]                mem_wdata,
    output logic                                   prot_we,
    output logic [1:0]                             prot_op,
    output logic                                   aborted
);
    import wcs_pkg::*;

    localparam int PG_W   = $clog2(PAGE_BYTES);
    localparam int ROW_W  = ADDR_W - PG_W;
    localparam int DATA_W = PAGE_BYTES * 8;

    typedef struct packed {
        logic                  busy;
        logic                  armed;
        logic                  cancel;
        wr_kind_e              kind;
        logic                  mem_we;
        logic [ROW_W-1:0]      mem_row;
        logic [PAGE_BYTES-1:0] mem_be;
        logic [DATA_W-1:0]     mem_wdata;
        logic                  prot_we;
        wr_kind_e              prot_op;
        logic                  aborted;
    } seq_t;

    seq_t q, d;

    logic                  buf_base, buf_clr, buf_push;
    logic [PAGE_BYTES-1:0] buf_mask;
    logic [DATA_W-1:0]     buf_data;
    logic [ROW_W-1:0]      buf_row;
    logic                  tmr_load, tmr_expired;
    logic                  window_open;

    wcs_page_buf #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) page_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_base  (buf_base),
        .base_addr (txn_addr),
        .clr       (buf_clr),
        .push      (buf_push),
        .push_data (byte_data),
        .mask      (buf_mask),
        .data      (buf_data),
        .row       (buf_row)
    );

    wcs_busy_timer #(
        .WR_CYCLES (WR_CYCLES)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .run     (q.busy),
        .expired (tmr_expired)
    );

    always_comb begin
        d           = q;
        d.mem_we    = 1'b0;
        d.mem_row   = '0;
        d.mem_be    = '0;
        d.mem_wdata = '0;
        d.prot_we   = 1'b0;
        d.prot_op   = KIND_PAGE;
        d.aborted   = 1'b0;
        buf_base    = 1'b0;
        buf_clr     = 1'b0;
        buf_push    = 1'b0;
        tmr_load    = 1'b0;
        window_open = 1'b0;

        if (q.busy) begin
            // Busy: bus inputs are masked; only the pin and the timer matter.
            if (wp_pin) begin
                d.busy    = 1'b0;
                d.armed   = 1'b0;
                d.aborted = 1'b1;
                buf_clr   = 1'b1;
                if (q.kind == KIND_PAGE) begin
                    d.mem_we  = 1'b1;
                    d.mem_row = buf_row;
                    d.mem_be  = buf_mask;   // data stays zero: visible corruption
                end
            end else if (tmr_expired) begin
                d.busy  = 1'b0;
                d.armed = 1'b0;
                buf_clr = 1'b1;
                if (q.kind == KIND_PAGE) begin
                    d.mem_we    = 1'b1;
                    d.mem_row   = buf_row;
                    d.mem_be    = buf_mask;
                    d.mem_wdata = buf_data;
                end else begin
                    d.prot_we = 1'b1;
                    d.prot_op = q.kind;
                end
            end
        end else if (txn_begin) begin
            buf_base = 1'b1;
            d.armed  = 1'b0;
            d.cancel = 1'b0;
            d.kind   = wr_kind_e'(txn_kind);
        end else begin
            window_open = q.armed | (first_d0 & ~q.cancel);
            if (window_open && wp_pin) begin
                d.cancel = 1'b1;
                d.armed  = 1'b0;
                buf_clr  = 1'b1;
            end else begin
                if (first_d0 && !q.cancel) d.armed = 1'b1;
                buf_push = byte_valid & ~q.cancel;
                if (wr_start && q.armed) begin
                    d.armed = 1'b0;
                    if (!supply_low) begin
                        d.busy   = 1'b1;
                        tmr_load = 1'b1;
                    end else begin
                        buf_clr = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy      = q.busy;
    assign mem_we    = q.mem_we;
    assign mem_row   = q.mem_row;
    assign mem_be    = q.mem_be;
    assign mem_wdata = q.mem_wdata;
    assign prot_we   = q.prot_we;
    assign prot_op   = q.prot_op;
    assign aborted   = q.aborted;

endmodule

// File: rtl/wcs_checker.sv
module wcs_checker #(
    parameter int WR_CYCLES = 625000
) (
    input logic clk,
    input logic rst_n,
    input logic wr_start,
    input logic wp_pin,
    input logic supply_low,
    input logic busy,
    input logic mem_we,
    input logic prot_we,
    input logic aborted
);
    int unsigned run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    assert_start_needs_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_start));

    assert_no_start_low_supply_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(supply_low));

    assert_commit_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || prot_we) |-> $past(busy));

    assert_full_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we || prot_we) && !aborted) |-> (run_len == WR_CYCLES));

    assert_single_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && prot_we));

    assert_abort_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        aborted |-> ($past(wp_pin) && $past(busy)));

    assert_busy_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wp_pin) |=> (busy || mem_we || prot_we));

endmodule

bind wr_cycle_seq wcs_checker #(.WR_CYCLES(WR_CYCLES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_start   (wr_start),
    .wp_pin     (wp_pin),
    .supply_low (supply_low),
    .busy       (busy),
    .mem_we     (mem_we),
    .prot_we    (prot_we),
    .aborted    (aborted)
);

// File: tb/wr_cycle_seq_tb_top.sv
module wr_cycle_seq_tb_top;

    localparam int AW  = 8;
    localparam int PB  = 16;
    localparam int WRC = 40;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         txn_begin = 1'b0;
    logic [7:0]   txn_addr = '0;
    logic [1:0]   txn_kind = '0;
    logic         first_d0 = 1'b0;
    logic         byte_valid = 1'b0;
    logic [7:0]   byte_data = '0;
    logic         wr_start = 1'b0;
    logic         wp_pin = 1'b0;
    logic         supply_low = 1'b0;
    logic         busy, mem_we, prot_we, aborted;
    logic [3:0]   mem_row;
    logic [15:0]  mem_be;
    logic [127:0] mem_wdata;
    logic [1:0]   prot_op;

    always #4 clk = ~clk;

    wr_cycle_seq #(.ADDR_W(AW), .PAGE_BYTES(PB), .WR_CYCLES(WRC)) dut_i (
        .clk(clk), .rst_n(rst_n), .txn_begin(txn_begin), .txn_addr(txn_addr),
        .txn_kind(txn_kind), .first_d0(first_d0), .byte_valid(byte_valid),
        .byte_data(byte_data), .wr_start(wr_start), .wp_pin(wp_pin),
        .supply_low(supply_low), .busy(busy), .mem_we(mem_we), .mem_row(mem_row),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .prot_we(prot_we),
        .prot_op(prot_op), .aborted(aborted)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit          m_busy, m_armed, m_cancel;
    int          m_left, m_kind, m_row, m_ptr;
    logic [7:0]  m_page [PB];
    bit          m_have [PB];
    bit          e_mem_we, e_prot_we, e_aborted;
    logic [3:0]  e_row;
    logic [15:0] e_be;
    logic [127:0] e_wdata;
    logic [1:0]  e_op;

    function automatic logic [15:0] have_vec();
        logic [15:0] v = '0;
        for (int i = 0; i < PB; i++) v[i] = m_have[i];
        return v;
    endfunction

    function automatic logic [127:0] page_vec();
        logic [127:0] v = '0;
        for (int i = 0; i < PB; i++) if (m_have[i]) v[i*8 +: 8] = m_page[i];
        return v;
    endfunction

    task automatic m_clear();
        for (int i = 0; i < PB; i++) begin m_have[i] = 1'b0; m_page[i] = 8'h00; end
        m_armed = 1'b0;
    endtask

    always @(posedge clk) begin
        bit was_armed;
        e_mem_we = 0; e_prot_we = 0; e_aborted = 0;
        e_row = '0; e_be = '0; e_wdata = '0; e_op = '0;
        if (!rst_n) begin
            m_busy = 0; m_cancel = 0; m_left = 0; m_kind = 0; m_row = 0; m_ptr = 0;
            m_clear();
        end else if (m_busy) begin
            if (wp_pin) begin
                m_busy = 0; e_aborted = 1;
                if (m_kind == 0) begin e_mem_we = 1; e_row = 4'(m_row); e_be = have_vec(); end
                m_clear();
            end else if (m_left == 1) begin
                m_busy = 0;
                if (m_kind == 0) begin
                    e_mem_we = 1; e_row = 4'(m_row); e_be = have_vec(); e_wdata = page_vec();
                end else begin
                    e_prot_we = 1; e_op = 2'(m_kind);
                end
                m_clear();
            end else begin
                m_left--;
            end
        end else if (txn_begin) begin
            m_row = int'(txn_addr) / PB; m_ptr = int'(txn_addr) % PB;
            m_kind = int'(txn_kind); m_cancel = 0;
            m_clear();
        end else begin
            if ((m_armed || (first_d0 && !m_cancel)) && wp_pin) begin
                m_cancel = 1;
                m_clear();
            end else begin
                was_armed = m_armed;
                if (first_d0 && !m_cancel) m_armed = 1;
                if (byte_valid && !m_cancel) begin
                    m_page[m_ptr] = byte_data; m_have[m_ptr] = 1; m_ptr = (m_ptr + 1) % PB;
                end
                if (wr_start && was_armed) begin
                    m_armed = 0;
                    if (!supply_low) begin m_busy = 1; m_left = WRC; end
                    else m_clear();
                end
            end
        end
    end

    // every-cycle comparison, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R3", "busy",      {127'd0, busy},    {127'd0, m_busy});
            check("R4", "mem_we",    {127'd0, mem_we},  {127'd0, e_mem_we});
            check("R4", "mem_row",   {124'd0, mem_row}, {124'd0, e_row});
            check("R4", "mem_be",    {112'd0, mem_be},  {112'd0, e_be});
            check("R4", "mem_wdata", mem_wdata,         e_wdata);
            check("R6", "prot_we",   {127'd0, prot_we}, {127'd0, e_prot_we});
            check("R6", "prot_op",   {126'd0, prot_op}, {126'd0, e_op});
            check("R7", "aborted",   {127'd0, aborted}, {127'd0, e_aborted});
        end
    end

    // ---------------- observation of events ----------------
    int n_mem = 0, n_prot = 0, n_abort = 0, n_rise = 0, run = 0, last_len = 0;
    logic [3:0]   last_row;
    logic [15:0]  last_be;
    logic [127:0] last_data;
    logic [1:0]   last_op;
    bit           busy_prev = 1'b0;

    always @(negedge clk) begin
        if (mem_we) begin n_mem++; last_row = mem_row; last_be = mem_be; last_data = mem_wdata; end
        if (prot_we) begin n_prot++; last_op = prot_op; end
        if (aborted) n_abort++;
        if (busy && !busy_prev) n_rise++;
        if (busy) run++;
        else if (run != 0) begin last_len = run; run = 0; end
        busy_prev = busy;
    end

    // ---------------- stimulus tasks ----------------
    task automatic begin_txn(input logic [7:0] a, input logic [1:0] k);
        @(negedge clk); txn_begin = 1; txn_addr = a; txn_kind = k;
        @(negedge clk); txn_begin = 0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit first);
        @(negedge clk); first_d0 = first;
        @(negedge clk); first_d0 = 0; byte_valid = 1; byte_data = b;
        @(negedge clk); byte_valid = 0;
    endtask

    task automatic stop_bus();
        @(negedge clk); wr_start = 1;
        @(negedge clk); wr_start = 0;
    endtask

    task automatic wp_pulse();
        @(negedge clk); wp_pin = 1;
        @(negedge clk); wp_pin = 0;
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int base_mem, base_prot, base_abort, base_rise;
        logic [127:0] exp;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check("R1", "busy after reset",    {127'd0, busy},    128'd0);
        check("R1", "mem_we after reset",  {127'd0, mem_we},  128'd0);
        check("R1", "prot_we after reset", {127'd0, prot_we}, 128'd0);
        check("R1", "aborted after reset", {127'd0, aborted}, 128'd0);

        // R4 / R3: three bytes from 0x35
        begin_txn(8'h35, 2'd0);
        send_byte(8'hA1, 1); send_byte(8'hB2, 0); send_byte(8'hC3, 0);
        stop_bus();
        wait_idle();
        check("R3", "busy length",  last_len, WRC);
        check("R4", "commit count", n_mem, 1);
        check("R4", "row",          {124'd0, last_row}, 128'd3);
        check("R4", "byte enables", {112'd0, last_be},  128'h00E0);
        check("R4", "page data",    last_data, 128'hC3B2A1 << 40);

        // R4: 18 bytes from 0x7E wrap twice over columns 14 and 15
        begin_txn(8'h7E, 2'd0);
        for (int k = 0; k < 18; k++) send_byte(8'(8'h10 + k), k == 0);
        stop_bus();
        wait_idle();
        exp = '0;
        for (int k = 0; k < 18; k++) exp[((14 + k) % 16) * 8 +: 8] = 8'(8'h10 + k);
        check("R4", "rollover row",  {124'd0, last_row}, 128'd7);
        check("R4", "rollover be",   {112'd0, last_be},  128'hFFFF);
        check("R4", "rollover data", last_data, exp);

        // R2: stop without any data byte
        base_rise = n_rise;
        begin_txn(8'h00, 2'd0);
        stop_bus();
        repeat (5) @(negedge clk);
        check("R2", "no cycle without data", n_rise - base_rise, 0);

        // R5: commands during busy are ignored
        base_mem = n_mem; base_rise = n_rise;
        begin_txn(8'h10, 2'd0);
        send_byte(8'h77, 1);
        stop_bus();
        begin_txn(8'h20, 2'd0);
        send_byte(8'hEE, 1);
        stop_bus();
        check("R5", "still busy during injected command", {127'd0, busy}, 128'd1);
        wait_idle();
        repeat (5) @(negedge clk);
        check("R5", "single commit",   n_mem - base_mem, 1);
        check("R5", "single cycle",    n_rise - base_rise, 1);
        check("R5", "original row",    {124'd0, last_row}, 128'd1);
        check("R5", "original be",     {112'd0, last_be},  128'h0001);
        check("R5", "original data",   last_data, 128'h77);

        // R6: protection commands
        base_mem = n_mem; base_prot = n_prot;
        begin_txn(8'h00, 2'd1); send_byte(8'hFF, 1); stop_bus(); wait_idle();
        check("R6", "set protection pulse", n_prot - base_prot, 1);
        check("R6", "set protection op", {126'd0, last_op}, 128'd1);
        begin_txn(8'h00, 2'd3); send_byte(8'hFF, 1); stop_bus(); wait_idle();
        check("R6", "permanent protection op", {126'd0, last_op}, 128'd3);
        check("R6", "no array write", n_mem - base_mem, 0);
        check("R3", "protection busy length", last_len, WRC);

        // R7: abort in the middle of a page write
        base_abort = n_abort; base_mem = n_mem;
        begin_txn(8'h42, 2'd0);
        send_byte(8'h5A, 1); send_byte(8'h6B, 0);
        stop_bus();
        repeat (9) @(negedge clk);
        wp_pulse();
        wait_idle();
        check("R7", "aborted pulse", n_abort - base_abort, 1);
        check("R7", "busy cut short", last_len, 11);
        check("R7", "scrub write", n_mem - base_mem, 1);
        check("R7", "scrub row",  {124'd0, last_row}, 128'd4);
        check("R7", "scrub be",   {112'd0, last_be},  128'h000C);
        check("R7", "scrub data", last_data, 128'd0);

        // R8: pin high inside window before the stop
        base_mem = n_mem; base_rise = n_rise;
        begin_txn(8'h00, 2'd0);
        send_byte(8'h11, 1);
        wp_pulse();
        send_byte(8'h22, 0);
        stop_bus();
        repeat (5) @(negedge clk);
        check("R8", "no cycle after cancel", n_rise - base_rise, 0);
        check("R8", "no write after cancel", n_mem - base_mem, 0);

        // R9: pin high before first data byte
        base_mem = n_mem;
        begin_txn(8'h30, 2'd0);
        wp_pulse();
        send_byte(8'h33, 1);
        stop_bus();
        wait_idle();
        check("R9", "write unaffected", n_mem - base_mem, 1);
        check("R9", "data unaffected", last_data, 128'h33);

        // R10: supply low at the stop
        base_rise = n_rise;
        supply_low = 1;
        begin_txn(8'h50, 2'd0);
        send_byte(8'h44, 1);
        stop_bus();
        supply_low = 0;
        repeat (5) @(negedge clk);
        check("R10", "no cycle on low supply", n_rise - base_rise, 0);
        stop_bus();
        repeat (5) @(negedge clk);
        check("R10", "dropped command stays dropped", n_rise - base_rise, 0);

        // R11: abort during a protection command
        base_abort = n_abort; base_prot = n_prot; base_mem = n_mem;
        begin_txn(8'h00, 2'd2);
        send_byte(8'hFF, 1);
        stop_bus();
        repeat (5) @(negedge clk);
        wp_pulse();
        wait_idle();
        check("R11", "aborted pulse", n_abort - base_abort, 1);
        check("R11", "no protection update", n_prot - base_prot, 0);
        check("R11", "no array write", n_mem - base_mem, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule